// File: doc/BRIEF.md
# Transport Packet Identifier Filter

This block screens a byte-serial stream of fixed-length transport packets. Each packet carries a 13-bit identifier in its header. Only packets whose identifier is listed in a small table of slots that the host loads are passed on. Bytes enter one per cycle under a valid strobe, with a start strobe on the first byte of each packet. Forwarded packets leave as a stream of 32-bit words, with a valid pulse per word and an end flag on the last word.

Slot 0 has two roles. It is a normal match entry, and it also holds three global controls: pass every packet, discard every packet, and the byte order used to pack the output words. The block holds the first header bytes until the identifier is known, so a forwarded packet leaves whole. Table writes are staged. A packet in flight always sees the table as it stood when that packet started.

Top module: `ts_pid_filter`

## Requirements
- R1: After reset, out_valid and out_eop are low. Every slot is released (identifier 0x1FFF, enable clear), and slot 0 has its discard bit (bit 13) set, so no packet is forwarded until the host writes slot 0.
- R2: A write with wr_en high loads wr_data into the slot selected by wr_addr[4:2]. wr_addr[1:0] are ignored. In each slot, bits 12:0 hold the identifier and bit 15 is the enable.
- R3: When slot 0 bit 13 is clear, a packet is forwarded if some enabled slot holds its identifier. The identifier is the low 5 bits of header byte 1 (as bits 12:8) followed by byte 2 (bits 7:0). A packet that matches no enabled slot, including one whose identifier sits in a disabled slot, produces no output.
- R4: While slot 0 bit 16 is set and bit 13 is clear, every packet with a valid sync byte is forwarded, whatever its identifier.
- R5: While slot 0 bit 13 is set, no packet is forwarded. This holds even when bit 16 is set or a slot matches.
- R6: Stream byte 4k+j of a packet goes into output word k. It occupies bits 8j+7:8j when slot 0 bit 14 is 1, and bits 31-8j:24-8j when bit 14 is 0.
- R7: A forwarded packet of PKT_BYTES bytes yields exactly PKT_BYTES/4 words. Each word is a one-cycle out_valid pulse in the cycle after its fourth byte is accepted. out_eop is high only with the last word.
- R8: A start byte other than 0x47 causes the whole packet to be dropped. Bytes that arrive without a start strobe while no packet is open are ignored, and the next valid start is filtered normally.
- R9: A slot write made while a packet is in progress does not affect that packet. It takes effect from the next packet.
- R10: Cycles with in_valid low inside a packet pause it without changing the bytes or words produced.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input byte valid |
| in_sop | input | 1 | First byte of a packet |
| in_data | input | 8 | Input byte |
| wr_en | input | 1 | Slot write strobe |
| wr_addr | input | $clog2(NUM_SLOTS)+2 | Byte address of the slot (slot = addr/4) |
| wr_data | input | 32 | Slot write value |
| out_valid | output | 1 | Output word valid |
| out_data | output | 32 | Packed output word |
| out_eop | output | 1 | Last word of a packet |

## Verification
The bench keeps the default eight slots, so every slot index and slot 0's dual role are exercised. It sets PKT_BYTES to 24 so that packets are short. With short packets, a run holds dozens of packets with back-to-back starts, idle gaps, writes in the middle of a packet and random table reloads. The end-of-packet word and the header-to-word hand-off therefore come up many times.

// File: rtl/ts_filt_pkg.sv
package ts_filt_pkg;
  localparam int SLOT_W   = 17;
  localparam int PID_W    = 13;
  localparam int HALT_BIT = 13;
  localparam int LE_BIT   = 14;
  localparam int EN_BIT   = 15;
  localparam int ALL_BIT  = 16;
  localparam logic [7:0] SYNC_BYTE = 8'h47;
  localparam logic [SLOT_W-1:0] SLOT_RELEASED = 17'h01FFF;
  localparam logic [SLOT_W-1:0] SLOT0_RESET   = 17'h03FFF;

  typedef enum logic [1:0] {ST_IDLE, ST_HDR, ST_PASS, ST_SKIP} pkt_st_e;
endpackage

// File: rtl/ts_slot_bank.sv
module ts_slot_bank import ts_filt_pkg::*; #(
  parameter int NUM_SLOTS = 8,
  localparam int IDX_W = $clog2(NUM_SLOTS)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_en,
  input  logic [IDX_W-1:0]            wr_idx,
  input  logic [SLOT_W-1:0]           wr_val,
  input  logic                        commit,
  output logic [NUM_SLOTS*SLOT_W-1:0] active_o
);
  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
    localparam logic [SLOT_W-1:0] RST_V = (i == 0) ? SLOT0_RESET : SLOT_RELEASED;
    logic              sel;
    logic [SLOT_W-1:0] stage_q, stage_d, live_q, live_d;

    assign sel = wr_en && (wr_idx == IDX_W'(i));

    always_comb begin
      stage_d = sel    ? wr_val  : stage_q;
      live_d  = commit ? stage_q : live_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stage_q <= RST_V;
        live_q  <= RST_V;
      end else begin
        stage_q <= stage_d;
        live_q  <= live_d;
      end
    end

    assign active_o[i*SLOT_W +: SLOT_W] = live_q;
  end
endmodule

// File: rtl/ts_pid_match.sv
module ts_pid_match import ts_filt_pkg::*; #(
  parameter int NUM_SLOTS = 8
) (
  input  logic [NUM_SLOTS*SLOT_W-1:0] table_i,
  input  logic [PID_W-1:0]            pid_i,
  output logic                        pass_o,
  output logic                        le_o
);
  logic [NUM_SLOTS-1:0] hit;
  logic [SLOT_W-1:0]    ctl;
  logic                 unused_tbl;

  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_cmp
    logic [SLOT_W-1:0] ent;
    assign ent    = table_i[i*SLOT_W +: SLOT_W];
    assign hit[i] = ent[EN_BIT] && (ent[PID_W-1:0] == pid_i);
  end

  assign ctl        = table_i[SLOT_W-1:0];
  assign pass_o     = !ctl[HALT_BIT] && (ctl[ALL_BIT] || (|hit));
  assign le_o       = ctl[LE_BIT];
  assign unused_tbl = ^table_i;
endmodule

// File: rtl/ts_word_pack.sv
module ts_word_pack (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        load_hdr,
  input  logic [7:0]  hdr1,
  input  logic [7:0]  hdr2,
  input  logic [7:0]  sync_b,
  input  logic        push,
  input  logic [7:0]  byte_i,
  input  logic        last_i,
  input  logic        le_i,
  output logic        out_valid,
  output logic [31:0] out_data,
  output logic        out_eop
);
  logic [1:0]       lane_q, lane_d;
  logic [2:0][7:0]  acc_q, acc_d;
  logic             vld_q, vld_d, eop_q, eop_d;
  logic [31:0]      data_q, data_d;

  function automatic logic [31:0] pack_word(input logic [3:0][7:0] b, input logic le);
    logic [31:0] w;
    w = '0;
    for (int j = 0; j < 4; j++) begin
      if (le) w[8*j +: 8]     = b[j];
      else    w[8*(3-j) +: 8] = b[j];
    end
    return w;
  endfunction

  always_comb begin
    lane_d = lane_q;
    acc_d  = acc_q;
    vld_d  = 1'b0;
    eop_d  = 1'b0;
    data_d = data_q;
    if (load_hdr) begin
      acc_d  = {hdr2, hdr1, sync_b};
      lane_d = 2'd3;
    end else if (push) begin
      case (lane_q)
        2'd0: acc_d[0] = byte_i;
        2'd1: acc_d[1] = byte_i;
        2'd2: acc_d[2] = byte_i;
        default: begin
          vld_d  = 1'b1;
          eop_d  = last_i;
          data_d = pack_word({byte_i, acc_q[2], acc_q[1], acc_q[0]}, le_i);
        end
      endcase
      lane_d = lane_q + 2'd1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lane_q <= '0;
      acc_q  <= '0;
      vld_q  <= 1'b0;
      eop_q  <= 1'b0;
      data_q <= '0;
    end else begin
      lane_q <= lane_d;
      acc_q  <= acc_d;
      vld_q  <= vld_d;
      eop_q  <= eop_d;
      if (vld_d) data_q <= data_d;
    end
  end

  assign out_valid = vld_q;
  assign out_eop   = eop_q;
  assign out_data  = data_q;
endmodule

// File: rtl/ts_pid_filter.sv
module ts_pid_filter import ts_filt_pkg::*; #(
  parameter int NUM_SLOTS = 8,
  parameter int PKT_BYTES = 188,
  localparam int IDX_W  = $clog2(NUM_SLOTS),
  localparam int ADDR_W = IDX_W + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              in_sop,
  input  logic [7:0]        in_data,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [31:0]       wr_data,
  output logic              out_valid,
  output logic [31:0]       out_data,
  output logic              out_eop
);
  localparam int CNT_W = $clog2(PKT_BYTES);

  pkt_st_e    st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [7:0] hdr1_q, hdr1_d;
  logic       commit, busy, last_byte, load_hdr, push, fwd, le;
  logic [NUM_SLOTS*SLOT_W-1:0] active_flat;
  logic       unused_wr;

  assign unused_wr = ^{wr_addr[1:0], wr_data[31:SLOT_W]};
  assign busy      = (st_q != ST_IDLE);
  assign commit    = !busy;
  assign last_byte = (cnt_q == CNT_W'(PKT_BYTES - 1));

  ts_slot_bank #(.NUM_SLOTS(NUM_SLOTS)) u_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_idx   (wr_addr[ADDR_W-1:2]),
    .wr_val   (wr_data[SLOT_W-1:0]),
    .commit   (commit),
    .active_o (active_flat)
  );

  ts_pid_match #(.NUM_SLOTS(NUM_SLOTS)) u_match (
    .table_i (active_flat),
    .pid_i   ({hdr1_q[4:0], in_data}),
    .pass_o  (fwd),
    .le_o    (le)
  );

  always_comb begin
    st_d     = st_q;
    cnt_d    = cnt_q;
    hdr1_d   = hdr1_q;
    load_hdr = 1'b0;
    push     = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (in_valid && in_sop && (in_data == SYNC_BYTE)) begin
          cnt_d = CNT_W'(1);
          st_d  = ST_HDR;
        end
      end
      ST_HDR: begin
        if (in_valid) begin
          if (cnt_q == CNT_W'(1)) begin
            hdr1_d = in_data;
            cnt_d  = CNT_W'(2);
          end else begin
            cnt_d = CNT_W'(3);
            if (fwd) begin
              load_hdr = 1'b1;
              st_d     = ST_PASS;
            end else begin
              st_d = ST_SKIP;
            end
          end
        end
      end
      ST_PASS, ST_SKIP: begin
        if (in_valid) begin
          push = (st_q == ST_PASS);
          if (last_byte) st_d  = ST_IDLE;
          else           cnt_d = cnt_q + CNT_W'(1);
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      hdr1_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      if (in_valid) hdr1_q <= hdr1_d;
    end
  end

  ts_word_pack u_pack (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_hdr  (load_hdr),
    .hdr1      (hdr1_q),
    .hdr2      (in_data),
    .sync_b    (SYNC_BYTE),
    .push      (push),
    .byte_i    (in_data),
    .last_i    (last_byte),
    .le_i      (le),
    .out_valid (out_valid),
    .out_data  (out_data),
    .out_eop   (out_eop)
  );
endmodule

// File: rtl/ts_pid_filter_chk.sv
module ts_pid_filter_chk import ts_filt_pkg::*; #(
  parameter int NUM_SLOTS = 8,
  parameter int PKT_BYTES = 188
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        out_valid,
  input logic                        out_eop,
  input logic                        busy,
  input logic [NUM_SLOTS*SLOT_W-1:0] active_flat
);
  localparam int WORDS = PKT_BYTES / 4;
  localparam int WC_W  = $clog2(WORDS) + 1;

  logic [WC_W-1:0] wcnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                wcnt_q <= '0;
    else if (out_valid) begin
      if (out_eop)             wcnt_q <= '0;
      else                     wcnt_q <= wcnt_q + WC_W'(1);
    end
  end

  a_r7_eop_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
    out_eop |-> out_valid);

  a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);

  a_r7_last_word_count: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_eop) |-> (wcnt_q == WC_W'(WORDS - 1)));

  a_r7_no_overlong: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_eop) |-> (wcnt_q < WC_W'(WORDS - 1)));

  a_r9_table_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(active_flat));
endmodule

bind ts_pid_filter ts_pid_filter_chk #(.NUM_SLOTS(NUM_SLOTS), .PKT_BYTES(PKT_BYTES)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .out_valid   (out_valid),
  .out_eop     (out_eop),
  .busy        (busy),
  .active_flat (active_flat)
);

// File: tb/ts_pid_filter_test.sv
`timescale 1ns/1ps
module ts_pid_filter_test;
  localparam int NS  = 8;
  localparam int IW  = 3;
  localparam int PKT = 24;

  logic clk = 1'b0;
  logic rst_n;
  logic in_valid, in_sop, wr_en;
  logic [7:0]  in_data;
  logic [IW+1:0] wr_addr;
  logic [31:0] wr_data;
  logic        out_valid, out_eop;
  logic [31:0] out_data;

  int nchk = 0, nfail = 0;
  bit done = 0;
  logic [16:0] tbl [NS];
  logic [31:0] exp_data [$];
  logic        exp_eop  [$];
  string       exp_tag  [$];

  always #2.5 clk = ~clk;

  ts_pid_filter #(.NUM_SLOTS(NS), .PKT_BYTES(PKT)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sop(in_sop), .in_data(in_data),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .out_valid(out_valid), .out_data(out_data), .out_eop(out_eop));

  task automatic check(input bit ok, input string tag, input logic [32:0] got, input logic [32:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  function automatic bit model_fwd(input logic [12:0] pid, input logic [16:0] t [NS]);
    bit hit = 0;
    for (int s = 0; s < NS; s++) if (t[s][15] && t[s][12:0] == pid) hit = 1;
    return !t[0][13] && (t[0][16] || hit);
  endfunction

  task automatic wr_slot(input int idx, input logic [31:0] v, input logic [1:0] lo);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = {idx[IW-1:0], lo}; wr_data = v;
    @(negedge clk);
    wr_en = 1'b0;
    tbl[idx] = v[16:0];
  endtask

  task automatic send_pkt(input logic [12:0] pid, input logic [7:0] sync, input bit gaps,
                          input int wr_at, input int wr_idx, input logic [31:0] wr_val,
                          input string tag);
    logic [7:0]  b [PKT];
    logic [16:0] snap [NS];
    logic [31:0] w;
    snap = tbl;
    b[0] = sync;
    b[1] = {3'($urandom), pid[12:8]};
    b[2] = pid[7:0];
    for (int i = 3; i < PKT; i++) b[i] = 8'($urandom);
    if (sync == 8'h47 && model_fwd(pid, snap)) begin
      for (int k = 0; k < PKT/4; k++) begin
        w = '0;
        for (int j = 0; j < 4; j++) begin
          if (snap[0][14]) w[8*j +: 8]     = b[4*k+j];
          else             w[8*(3-j) +: 8] = b[4*k+j];
        end
        exp_data.push_back(w);
        exp_eop.push_back(k == PKT/4 - 1);
        exp_tag.push_back(tag);
      end
    end
    for (int i = 0; i < PKT; i++) begin
      while (gaps && ($urandom % 3 == 0)) begin
        @(negedge clk);
        in_valid = 1'b0; in_sop = 1'b0; wr_en = 1'b0;
      end
      @(negedge clk);
      in_valid = 1'b1; in_sop = (i == 0); in_data = b[i];
      wr_en = (i == wr_at);
      if (i == wr_at) begin
        wr_addr = {wr_idx[IW-1:0], 2'b00}; wr_data = wr_val;
        tbl[wr_idx] = wr_val[16:0];
      end
    end
    @(negedge clk);
    in_valid = 1'b0; in_sop = 1'b0; wr_en = 1'b0;
  endtask

  task automatic flush(input string tag);
    repeat (10) @(negedge clk);
    check(exp_data.size() == 0, tag, 33'(exp_data.size()), 33'd0);
    exp_data.delete(); exp_eop.delete(); exp_tag.delete();
  endtask

  // output monitor
  initial begin
    logic [31:0] d; logic e; string t;
    @(posedge rst_n);
    forever begin
      @(negedge clk);
      if (out_valid) begin
        if (exp_data.size() == 0) begin
          check(1'b0, "R3 unexpected word", {out_eop, out_data}, 33'd0);
        end else begin
          d = exp_data.pop_front(); e = exp_eop.pop_front(); t = exp_tag.pop_front();
          check(out_data == d && out_eop == e, t, {out_eop, out_data}, {e, d});
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'd4242));
    rst_n = 1'b0; in_valid = 0; in_sop = 0; in_data = 0; wr_en = 0; wr_addr = 0; wr_data = 0;
    tbl[0] = 17'h03FFF;
    for (int s = 1; s < NS; s++) tbl[s] = 17'h01FFF;
    repeat (4) @(negedge clk);
    check(out_valid == 0 && out_eop == 0, "R1 outputs in reset", {out_eop, 31'd0, out_valid}, 33'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check(out_valid == 0 && out_eop == 0, "R1 outputs after reset", {out_eop, 31'd0, out_valid}, 33'd0);
    send_pkt(13'h1FFF, 8'h47, 0, -1, 0, 0, "R1");
    send_pkt(13'h0100, 8'h47, 0, -1, 0, 0, "R1");
    flush("R1 nothing forwarded after reset");

    // R2: address low bits ignored, fields at 12:0 and 15
    wr_slot(0, 32'h0000_0000, 2'b00);
    wr_slot(3, 32'h0000_8123, 2'b11);
    send_pkt(13'h0123, 8'h47, 0, -1, 0, 0, "R2 slot 3 match");
    send_pkt(13'h0124, 8'h47, 0, -1, 0, 0, "R3 mismatch");
    flush("R3 mismatch dropped");
    wr_slot(5, 32'h0000_0124, 2'b01);
    send_pkt(13'h0124, 8'h47, 0, -1, 0, 0, "R3 disabled slot");
    flush("R3 disabled slot dropped");

    // R6 little-endian, slot 0 as a match entry
    wr_slot(0, 32'h0000_C050, 2'b00);
    send_pkt(13'h0050, 8'h47, 0, -1, 0, 0, "R6 little-endian");
    send_pkt(13'h0123, 8'h47, 0, -1, 0, 0, "R7 back-to-back");
    flush("R6");

    // R4 pass all
    wr_slot(0, 32'h0001_4000, 2'b00);
    send_pkt(13'h1FFF, 8'h47, 0, -1, 0, 0, "R4 pass all");
    send_pkt(13'h0777, 8'h47, 0, -1, 0, 0, "R4 pass all");
    flush("R4");

    // R5 discard wins
    wr_slot(0, 32'h0001_A050, 2'b00);
    send_pkt(13'h0050, 8'h47, 0, -1, 0, 0, "R5 discard");
    send_pkt(13'h0123, 8'h47, 0, -1, 0, 0, "R5 discard");
    flush("R5 discard wins");

    // R8 bad sync
    wr_slot(0, 32'h0001_0000, 2'b00);
    send_pkt(13'h0010, 8'h46, 0, -1, 0, 0, "R8 bad sync");
    flush("R8 bad sync dropped");
    send_pkt(13'h0010, 8'h47, 0, -1, 0, 0, "R8 recovery");
    flush("R8 recovery");

    // R9 mid-packet write takes effect next packet
    send_pkt(13'h0011, 8'h47, 0, 10, 0, 32'h0000_2000, "R9 current packet");
    send_pkt(13'h0011, 8'h47, 0, -1, 0, 0, "R9 next packet");
    flush("R9 write deferred");
    send_pkt(13'h0123, 8'h47, 0, 5, 0, 32'h0001_0000, "R9 current dropped");
    send_pkt(13'h0222, 8'h47, 0, -1, 0, 0, "R9 next forwarded");
    flush("R9");

    // R10 gaps
    send_pkt(13'h0033, 8'h47, 1, -1, 0, 0, "R10 gaps");
    wr_slot(0, 32'h0001_4000, 2'b00);
    send_pkt(13'h0034, 8'h47, 1, -1, 0, 0, "R10 gaps LE");
    flush("R10");

    // random phase
    for (int p = 0; p < 40; p++) begin
      if (p % 5 == 0) begin
        for (int s = NS-1; s >= 0; s--) begin
          v = '0;
          v[12:0] = 13'($urandom % 16);
          v[15]   = 1'($urandom);
          if (s == 0) begin
            v[13] = ($urandom % 10 == 0);
            v[14] = 1'($urandom);
            v[16] = ($urandom % 7 == 0);
          end
          wr_slot(s, v, 2'($urandom));
        end
      end
      send_pkt(13'($urandom % 16), 8'h47, 1'($urandom), -1, 0, 0, "R3 random");
    end
    flush("R3 random");

    done = 1;
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule